// File: doc/BRIEF.md
# Mixer Oscillator with Atomic Phase Offset

This block is the numerically controlled oscillator of a digital mixer. A 32-bit phase accumulator adds a frequency word on every clock. A 16-bit phase offset is added to the accumulator's top 16 bits, and the sum selects a point on one cycle of a sine wave. The block returns signed sine and cosine samples of that point, which a downstream complex multiplier uses to shift a data stream in frequency.

Software programs the oscillator through a small write port. The low and high halves of the frequency word only load holding registers. Writing the phase offset makes both halves and the offset take effect on the same clock edge, so the running tone never shows a half-updated setting. A control register can turn off this automatic commit. When it is off, a separate commit bit applies all staged values together. A synchronous clear restarts the accumulator from zero without touching the active settings.

Top module: `nco_mixer_osc`

## Requirements
- R1: While `rst` is high, every register is cleared: the accumulator, the staged values and the active frequency and offset are all zero, both outputs read 0, and automatic commit is enabled (control bit 0 = 1).
- R2: On each clock edge without `clr`, the accumulator becomes its previous value plus the active 32-bit frequency word, modulo 2^32.
- R3: The lookup phase is (accumulator bits [31:16] + active offset) mod 2^16. The offset never changes the accumulator itself.
- R4: A write to address 0 (frequency bits [15:0]) or to address 1 (frequency bits [31:16]) updates only the staged copy. The active frequency, the active offset and the outputs are not affected.
- R5: When automatic commit is enabled, a write to address 2 (phase offset) makes the written offset and the staged frequency word active on that same edge.
- R6: When automatic commit is disabled (address 3, bit 0 = 0), a write to address 2 only stages the offset. A write to address 3 with bit 1 = 1 makes the staged frequency and the staged offset active together, and bit 0 of that write sets the automatic-commit enable.
- R7: When `clr` is high at a clock edge, the accumulator becomes zero at that edge. The active frequency and offset stay as they were.
- R8: Let N = 2^LUT_AW, A = 2^(OUT_W-1) - 1 and T[i] = floor(A*sin(pi/2*(i+0.5)/N) + 0.5). The quadrant q is phase bits [15:14] and k is the next LUT_AW bits. Sine is T[k], T[N-1-k], -T[k], -T[N-1-k] for q = 0, 1, 2, 3. Cosine is T[N-1-k], -T[k], -T[N-1-k], T[k] for the same quadrants. Neither output ever equals -2^(OUT_W-1).
- R9: The outputs after clock edge e correspond to the accumulator and active offset held just before edge e-2. An offset committed at edge E therefore first shows on the outputs after edge E+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous accumulator clear |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 freq low, 1 freq high, 2 offset, 3 control |
| wr_data | input | REG_W | Write data |
| sin_o | output | OUT_W | Signed sine sample |
| cos_o | output | OUT_W | Signed cosine sample |

## Verification
The bench builds the block with LUT_AW = 6, a 64-entry quarter table. With this setting, a sweep with a phase step of 0x80 per clock visits every table entry in all four quadrants within a few hundred cycles. REG_W and OUT_W keep their defaults of 16. This keeps the full 32-bit accumulator, so a frequency word near 2^32 makes it wrap within a few clocks. It also gives the full 16-bit amplitude, so the largest table values are checked.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    SEL_FRQ_LO = 2'd0,
    SEL_FRQ_HI = 2'd1,
    SEL_POFF   = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  localparam int CTRL_AUTO_BIT   = 0;
  localparam int CTRL_COMMIT_BIT = 1;
endpackage

// File: rtl/nco_regs.sv
module nco_regs import nco_pkg::*; #(
  parameter int REG_W = 16,
  localparam int ACC_W = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [ACC_W-1:0] act_fw,
  output logic [REG_W-1:0] act_off,
  output logic             auto_en
);
  logic [REG_W-1:0] stg_lo, stg_hi, stg_off;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_lo  <= '0;
      stg_hi  <= '0;
      stg_off <= '0;
      act_fw  <= '0;
      act_off <= '0;
      auto_en <= 1'b1;
    end else if (wr_en) begin
      case (sel)
        SEL_FRQ_LO: stg_lo <= wr_data;
        SEL_FRQ_HI: stg_hi <= wr_data;
        SEL_POFF: begin
          stg_off <= wr_data;
          if (auto_en) begin
            act_fw  <= {stg_hi, stg_lo};
            act_off <= wr_data;
          end
        end
        SEL_CTRL: begin
          auto_en <= wr_data[CTRL_AUTO_BIT];
          if (wr_data[CTRL_COMMIT_BIT]) begin
            act_fw  <= {stg_hi, stg_lo};
            act_off <= stg_off;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nco_phase.sv
module nco_phase #(
  parameter int REG_W = 16,
  localparam int ACC_W = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [ACC_W-1:0] fw,
  input  logic [REG_W-1:0] off,
  output logic [ACC_W-1:0] acc,
  output logic [REG_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else            acc <= acc + fw;
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= acc[ACC_W-1 -: REG_W] + off;
  end
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int REG_W  = 16,
  parameter int OUT_W  = 16,
  parameter int LUT_AW = 8,
  localparam int QN    = 1 << LUT_AW,
  localparam int MAG_W = OUT_W - 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [REG_W-1:0]        phase,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam real PI_R  = 3.14159265358979;
  localparam real AMP_R = (2.0 ** (OUT_W - 1)) - 1.0;

  logic [MAG_W-1:0]  qrom [QN];
  logic [1:0]        quad, quad_q;
  logic [LUT_AW-1:0] idx;
  logic [MAG_W-1:0]  mag_s, mag_c;

  initial begin
    for (int i = 0; i < QN; i++) begin
      qrom[i] = MAG_W'($rtoi($floor(AMP_R * $sin(PI_R / 2.0 * (real'(i) + 0.5) / real'(QN)) + 0.5)));
    end
  end

  assign quad = phase[REG_W-1 -: 2];
  assign idx  = phase[REG_W-3 -: LUT_AW];

  // ROM read stage: odd quadrants mirror the sine index, even ones mirror the cosine index
  always_ff @(posedge clk) begin
    mag_s  <= qrom[quad[0] ? ~idx : idx];
    mag_c  <= qrom[quad[0] ? idx : ~idx];
    quad_q <= quad;
  end

  // Sign stage
  always_ff @(posedge clk) begin
    if (rst) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= quad_q[1] ? -$signed({1'b0, mag_s}) : $signed({1'b0, mag_s});
      cos_o <= (quad_q[1] ^ quad_q[0]) ? -$signed({1'b0, mag_c}) : $signed({1'b0, mag_c});
    end
  end
endmodule

// File: rtl/nco_mixer_osc.sv
module nco_mixer_osc import nco_pkg::*; #(
  parameter int REG_W  = 16,
  parameter int OUT_W  = 16,
  parameter int LUT_AW = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam int ACC_W = 2 * REG_W;

  logic [ACC_W-1:0] act_fw;
  logic [REG_W-1:0] act_off;
  logic             auto_en;
  logic [ACC_W-1:0] acc;
  logic [REG_W-1:0] phase;

  nco_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_fw(act_fw), .act_off(act_off), .auto_en(auto_en)
  );

  nco_phase #(.REG_W(REG_W)) u_phase (
    .clk(clk), .rst(rst), .clr(clr), .fw(act_fw), .off(act_off),
    .acc(acc), .phase(phase)
  );

  nco_sincos #(.REG_W(REG_W), .OUT_W(OUT_W), .LUT_AW(LUT_AW)) u_sincos (
    .clk(clk), .rst(rst), .phase(phase), .sin_o(sin_o), .cos_o(cos_o)
  );
endmodule

// File: rtl/nco_mixer_osc_chk.sv
module nco_mixer_osc_chk #(
  parameter int REG_W = 16,
  parameter int OUT_W = 16,
  localparam int ACC_W = 2 * REG_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clr,
  input logic                    wr_en,
  input logic [1:0]              wr_addr,
  input logic [REG_W-1:0]        wr_data,
  input logic [ACC_W-1:0]        act_fw,
  input logic [REG_W-1:0]        act_off,
  input logic                    auto_en,
  input logic [ACC_W-1:0]        acc,
  input logic signed [OUT_W-1:0] sin_o,
  input logic signed [OUT_W-1:0] cos_o
);
  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  assert_accum_step_R2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> acc == $past(acc) + $past(act_fw));

  assert_stage_only_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[1]) |=> ($stable(act_fw) && $stable(act_off)));

  assert_auto_commit_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2 && auto_en) |=> act_off == $past(wr_data));

  assert_no_auto_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2 && !auto_en) |=> ($stable(act_fw) && $stable(act_off)));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc == '0);

  assert_clear_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr_en) |=> ($stable(act_fw) && $stable(act_off)));

  assert_out_range_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sin_o != MOST_NEG && cos_o != MOST_NEG));
endmodule

bind nco_mixer_osc nco_mixer_osc_chk #(.REG_W(REG_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .act_fw(act_fw), .act_off(act_off), .auto_en(auto_en), .acc(acc),
  .sin_o(sin_o), .cos_o(cos_o)
);

// File: tb/nco_mixer_osc_bench.sv
module nco_mixer_osc_bench;
  localparam int  REG_W  = 16;
  localparam int  OUT_W  = 16;
  localparam int  LUT_AW = 6;
  localparam int  N      = 1 << LUT_AW;
  localparam real AMP    = (2.0 ** (OUT_W - 1)) - 1.0;
  localparam real PI     = 3.14159265358979;

  logic clk = 1'b0;
  logic rst, clr, wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic signed [OUT_W-1:0] sin_o, cos_o;

  int n_chk  = 0;
  int n_fail = 0;
  string cur_req = "R2";

  nco_mixer_osc #(.REG_W(REG_W), .OUT_W(OUT_W), .LUT_AW(LUT_AW)) u_nco_mixer_osc (
    .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sin_o(sin_o), .cos_o(cos_o)
  );

  always #10 clk = ~clk;

  function automatic int tab(int i);
    return $rtoi($floor(AMP * $sin(PI / 2.0 * (real'(i) + 0.5) / real'(N)) + 0.5));
  endfunction

  function automatic int exp_sin(bit [15:0] ph);
    int q = int'(ph[15:14]);
    int k = (int'(ph) >> (14 - LUT_AW)) & (N - 1);
    case (q)
      0: return tab(k);
      1: return tab(N - 1 - k);
      2: return -tab(k);
      default: return -tab(N - 1 - k);
    endcase
  endfunction

  function automatic int exp_cos(bit [15:0] ph);
    int q = int'(ph[15:14]);
    int k = (int'(ph) >> (14 - LUT_AW)) & (N - 1);
    case (q)
      0: return tab(N - 1 - k);
      1: return -tab(k);
      2: return -tab(N - 1 - k);
      default: return tab(k);
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit [31:0] m_acc, m_fw;
  bit [15:0] m_lo, m_hi, m_soff, m_off;
  bit        m_auto;
  bit [15:0] h0, h1, h2;
  int        n_edges;

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_fw = 0; m_lo = 0; m_hi = 0; m_soff = 0; m_off = 0;
      m_auto = 1; h0 = 0; h1 = 0; h2 = 0; n_edges = 0;
    end else begin
      h2 = h1; h1 = h0;
      h0 = m_acc[31:16] + m_off;
      m_acc = clr ? 32'd0 : m_acc + m_fw;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_lo = wr_data;
          2'd1: m_hi = wr_data;
          2'd2: begin
            m_soff = wr_data;
            if (m_auto) begin m_fw = {m_hi, m_lo}; m_off = wr_data; end
          end
          default: begin
            m_auto = wr_data[0];
            if (wr_data[1]) begin m_fw = {m_hi, m_lo}; m_off = m_soff; end
          end
        endcase
      end
      n_edges++;
    end
  end

  // Per-clock comparison of both outputs, tagged with the phase of the test (R9 timing)
  always @(negedge clk) begin
    if (!rst && n_edges >= 3) begin
      chk({cur_req, " R8 R9 sin"}, int'(sin_o), exp_sin(h2));
      chk({cur_req, " R8 R9 cos"}, int'(cos_o), exp_cos(h2));
    end
  end

  task automatic wr(bit [1:0] a, bit [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(4);
    chk("R1 sin in reset", int'(sin_o), 0);
    chk("R1 cos in reset", int'(cos_o), 0);
    rst = 1'b0;
    idle(5);
    chk("R1 idle sin", int'(sin_o), tab(0));

    cur_req = "R4";
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h0100);
    idle(10);
    chk("R4 freq staged only", int'(sin_o), tab(0));
    chk("R4 freq staged only cos", int'(cos_o), tab(N - 1));

    cur_req = "R5";
    wr(2'd2, 16'h0000);
    idle(50);

    cur_req = "R3";
    wr(2'd2, 16'h4000);
    idle(30);
    wr(2'd2, 16'hC321);
    idle(30);

    cur_req = "R2";
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'hF000);
    wr(2'd2, 16'h1111);
    idle(100);

    cur_req = "R7";
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    idle(10);
    @(negedge clk); clr = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h2000;
    @(negedge clk); clr = 1'b0; wr_en = 1'b0;
    idle(20);

    cur_req = "R6";
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0002);
    wr(2'd2, 16'h8000);
    idle(20);
    wr(2'd3, 16'h0003);
    idle(30);
    wr(2'd2, 16'h0700);
    idle(20);

    cur_req = "R8";
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0080);
    wr(2'd2, 16'h0000);
    idle(600);

    cur_req = "R9";
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    idle(6);
    chk("R9 settled sin", int'(sin_o), tab(0));
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h4000;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 edge E+0", int'(sin_o), tab(0));
    @(negedge clk);
    chk("R9 edge E+1", int'(sin_o), tab(0));
    @(negedge clk);
    chk("R9 edge E+2", int'(sin_o), tab(0));
    @(negedge clk);
    chk("R9 edge E+3", int'(sin_o), tab(N - 1));
    idle(5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule